// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Port

This block receives configuration words over a write-only three-wire serial link (serial clock, serial data and an active-low enable) and keeps the settings of a dual-band frequency synthesizer. It brings all three wires into the system clock domain through a synchronizer. Each synchronized rising serial-clock edge seen while the enable is low shifts one bit into a 22-bit word register. When the enable rises, the 4 bits sent last are decoded as an address, and the 18 bits sent before them are stored as data in the selected register.

Five registers are kept: a main configuration register (auxiliary output select and an auto-enable bit), a power register (IF and RF enable bits), two RF loop divider values and one IF loop divider value. The block also records which RF loop is active, which is the one whose divider was written last. A write to a divider raises a one-cycle retune request for that loop, so the downstream tuning sequencer can start. Reserved addresses are ignored.

Top module: `scfg_port`

## Requirements
- R1: After reset all register outputs are zero, the active RF loop is loop A (`rf_sel`=0), and both retune requests are low.
- R2: A word is the last 22 bits shifted in, most significant bit first. Word bits 21:4 are the 18-bit data field (data bit 17 is sent first) and word bits 3:0 are the address (address bit 3 is sent first, address bit 0 last).
- R3: Any number of extra bits sent before the 22 word bits has no effect on the stored result.
- R4: Address 0 stores data bits 14:12 as the 3-bit auxiliary select and data bit 3 as the auto-enable bit.
- R5: Address 2 stores data bit 1 as the IF enable and data bit 0 as the RF enable.
- R6: Address 3 stores all 18 data bits as the loop A divider, sets `rf_sel` to 0 and pulses `tune_rf` high for exactly one cycle.
- R7: Address 4 stores data bits 16:0 as the loop B divider, sets `rf_sel` to 1 and pulses `tune_rf` for one cycle.
- R8: Address 5 stores data bits 15:0 as the IF divider and pulses `tune_if` for one cycle. It leaves `rf_sel` unchanged, and the two retune requests are never high together.
- R9: A commit to address 1 or to addresses 6 through 15 changes no output and raises no retune request.
- R10: Serial clock edges seen while the enable is high do not shift. A commit that follows with no clock edges stores the word that was shifted earlier.
- R11: `if_on` is the IF enable OR the auto-enable bit, and `rf_on` is the RF enable OR the auto-enable bit. Writes are accepted whatever the power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data |
| ser_en_n | input | 1 | Active-low serial enable; its rising edge commits the word |
| aux_sel | output | 3 | Auxiliary output select |
| if_on | output | 1 | IF loop powered (enable or auto) |
| rf_on | output | 1 | RF loop powered (enable or auto) |
| rf_sel | output | 1 | Active RF loop: 0 = loop A, 1 = loop B |
| n_rf_a | output | 18 | Loop A divider value |
| n_rf_b | output | 17 | Loop B divider value |
| n_if | output | 16 | IF divider value |
| tune_rf | output | 1 | One-cycle retune request for the active RF loop |
| tune_if | output | 1 | One-cycle retune request for the IF loop |

## Verification
An enable rise driven between clock edges passes two synchronizer stages and reaches the commit detector after the second rising clk edge. The registers, `rf_sel` and the retune pulse then change on the third edge. The bench therefore samples on falling edges. It expects no pulse and old values at the second falling edge, new values and the pulse at the third, and the pulse low again at the fourth. Serial bits are held for several system clocks on each side of every serial clock edge, so each edge is seen exactly once after synchronization.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    localparam int DATA_W   = 18;
    localparam int ADDR_W   = 4;
    localparam int WORD_W   = DATA_W + ADDR_W;
    localparam int AUX_W    = 3;
    localparam int AUX_LSB  = 12;
    localparam int AUTO_BIT = 3;
    localparam int IFEN_BIT = 1;
    localparam int RFEN_BIT = 0;
    localparam int NA_W     = 18;
    localparam int NB_W     = 17;
    localparam int NIF_W    = 16;

    localparam logic [ADDR_W-1:0] ADR_CFG = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_PWR = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_NA  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_NB  = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_NIF = 4'd5;

    typedef struct packed {
        logic [AUX_W-1:0] aux;
        logic             auto_on;
        logic             if_en;
        logic             rf_en;
        logic [NA_W-1:0]  na;
        logic [NB_W-1:0]  nb;
        logic [NIF_W-1:0] nif;
        logic             rf_sel;
        logic             tune_rf;
        logic             tune_if;
    } regs_t;

    function automatic logic addr_reserved(input logic [ADDR_W-1:0] a);
        return !(a == ADR_CFG || a == ADR_PWR || a == ADR_NA ||
                 a == ADR_NB  || a == ADR_NIF);
    endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int             W      = 3,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= RST;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              enn_s,
    output logic [WORD_W-1:0] word_o,
    output logic              commit_o
);
    typedef struct packed {
        logic              sclk_prev;
        logic              enn_prev;
        logic [WORD_W-1:0] sh;
    } sh_t;

    sh_t sh_d, sh_q;
    logic shift_go;

    always_comb begin
        sh_d           = sh_q;
        sh_d.sclk_prev = sclk_s;
        sh_d.enn_prev  = enn_s;
        shift_go       = sclk_s && !sh_q.sclk_prev && !enn_s;
        if (shift_go) begin
            sh_d.sh = {sh_q.sh[WORD_W-2:0], sdat_s};
        end
        commit_o = enn_s && !sh_q.enn_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.sclk_prev <= 1'b0;
            sh_q.enn_prev  <= 1'b1;
            sh_q.sh        <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word_o = sh_q.sh;

    // R10
    shift_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sh_q.sh) |-> !$past(enn_s));

    // R2
    shift_on_clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sh_q.sh) |-> ($past(sclk_s) && !$past(sh_q.sclk_prev)));
endmodule

// File: rtl/scfg_regs.sv
module scfg_regs
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    output regs_t             regs_o
);
    regs_t rg_d, rg_q;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;

    assign addr = word_i[ADDR_W-1:0];
    assign data = word_i[WORD_W-1:ADDR_W];

    always_comb begin
        rg_d         = rg_q;
        rg_d.tune_rf = 1'b0;
        rg_d.tune_if = 1'b0;
        if (commit_i) begin
            case (addr)
                ADR_CFG: begin
                    rg_d.aux     = data[AUX_LSB +: AUX_W];
                    rg_d.auto_on = data[AUTO_BIT];
                end
                ADR_PWR: begin
                    rg_d.if_en = data[IFEN_BIT];
                    rg_d.rf_en = data[RFEN_BIT];
                end
                ADR_NA: begin
                    rg_d.na      = data[NA_W-1:0];
                    rg_d.rf_sel  = 1'b0;
                    rg_d.tune_rf = 1'b1;
                end
                ADR_NB: begin
                    rg_d.nb      = data[NB_W-1:0];
                    rg_d.rf_sel  = 1'b1;
                    rg_d.tune_rf = 1'b1;
                end
                ADR_NIF: begin
                    rg_d.nif     = data[NIF_W-1:0];
                    rg_d.tune_if = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign regs_o = rg_q;

    // R6
    tune_rf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.tune_rf |=> !rg_q.tune_rf);

    // R8
    tune_if_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.tune_if |=> !rg_q.tune_if);

    // R6
    na_write_selects_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rg_q.na) |-> (rg_q.tune_rf && !rg_q.rf_sel));

    // R7
    sel_moves_with_tune_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rg_q.rf_sel) |-> rg_q.tune_rf);

    // R8
    nif_moves_with_tune_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rg_q.nif) |-> rg_q.tune_if);

    // R9
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && addr_reserved(addr)) |=>
            ($stable(rg_q.aux) && $stable(rg_q.auto_on) && $stable(rg_q.if_en) &&
             $stable(rg_q.rf_en) && $stable(rg_q.na) && $stable(rg_q.nb) &&
             $stable(rg_q.nif) && $stable(rg_q.rf_sel) &&
             !rg_q.tune_rf && !rg_q.tune_if));
endmodule

// File: rtl/scfg_port.sv
module scfg_port
    import scfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_en_n,
    output logic [AUX_W-1:0] aux_sel,
    output logic             if_on,
    output logic             rf_on,
    output logic             rf_sel,
    output logic [NA_W-1:0]  n_rf_a,
    output logic [NB_W-1:0]  n_rf_b,
    output logic [NIF_W-1:0] n_if,
    output logic             tune_rf,
    output logic             tune_if
);
    logic [2:0]        pins_s;
    logic [WORD_W-1:0] word;
    logic              commit;
    regs_t             regs;

    scfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b001)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_clk, ser_dat, ser_en_n}),
        .dout (pins_s)
    );

    scfg_shift i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[2]),
        .sdat_s  (pins_s[1]),
        .enn_s   (pins_s[0]),
        .word_o  (word),
        .commit_o(commit)
    );

    scfg_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit),
        .word_i  (word),
        .regs_o  (regs)
    );

    assign aux_sel = regs.aux;
    assign if_on   = regs.if_en | regs.auto_on;
    assign rf_on   = regs.rf_en | regs.auto_on;
    assign rf_sel  = regs.rf_sel;
    assign n_rf_a  = regs.na;
    assign n_rf_b  = regs.nb;
    assign n_if    = regs.nif;
    assign tune_rf = regs.tune_rf;
    assign tune_if = regs.tune_if;

    // R8
    one_tune_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tune_rf, tune_if}));

    // R2
    commit_needs_enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_rf || tune_if) |-> $past(commit));
endmodule

// File: tb/test_scfg_port.sv
module test_scfg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
    logic [2:0]  aux_sel;
    logic        if_on, rf_on, rf_sel, tune_rf, tune_if;
    logic [17:0] n_rf_a;
    logic [16:0] n_rf_b;
    logic [15:0] n_if;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0]  e_aux = '0;
    logic        e_auto = 1'b0, e_ifen = 1'b0, e_rfen = 1'b0, e_sel = 1'b0;
    logic [17:0] e_na = '0;
    logic [16:0] e_nb = '0;
    logic [15:0] e_nif = '0;

    always #4 clk = ~clk;

    scfg_port i_scfg_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_en_n(ser_en_n), .aux_sel(aux_sel), .if_on(if_on), .rf_on(rf_on),
        .rf_sel(rf_sel), .n_rf_a(n_rf_a), .n_rf_b(n_rf_b), .n_if(n_if),
        .tune_rf(tune_rf), .tune_if(tune_if)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic exp_trf, input logic exp_tif);
        check({req, " aux_sel"}, 32'(aux_sel), 32'(e_aux));
        check({req, " if_on"},   32'(if_on),   32'(e_ifen | e_auto));
        check({req, " rf_on"},   32'(rf_on),   32'(e_rfen | e_auto));
        check({req, " rf_sel"},  32'(rf_sel),  32'(e_sel));
        check({req, " n_rf_a"},  32'(n_rf_a),  32'(e_na));
        check({req, " n_rf_b"},  32'(n_rf_b),  32'(e_nb));
        check({req, " n_if"},    32'(n_if),    32'(e_nif));
        check({req, " tune_rf"}, 32'(tune_rf), 32'(exp_trf));
        check({req, " tune_if"}, 32'(tune_if), 32'(exp_tif));
    endtask

    task automatic ser_bit(input logic b);
        ser_dat = b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clock_word(input logic [21:0] w);
        for (int i = 21; i >= 0; i--) ser_bit(w[i]);
    endtask

    // write one word; lead extra ones precede it (R3); model applies R4..R9
    task automatic write_word(input logic [3:0] a, input logic [17:0] d,
                              input int lead, input string req);
        logic trf, tif;
        ser_en_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < lead; i++) ser_bit(1'b1);
        clock_word({d, a});
        repeat (2) @(negedge clk);
        ser_en_n = 1'b1;
        repeat (2) @(negedge clk);
        check({req, " early tune_rf"}, 32'(tune_rf), 32'd0);
        check({req, " early tune_if"}, 32'(tune_if), 32'd0);
        @(negedge clk);
        trf = 1'b0;
        tif = 1'b0;
        case (a)
            4'd0: begin e_aux = d[14:12]; e_auto = d[3]; end
            4'd2: begin e_ifen = d[1]; e_rfen = d[0]; end
            4'd3: begin e_na = d; e_sel = 1'b0; trf = 1'b1; end
            4'd4: begin e_nb = d[16:0]; e_sel = 1'b1; trf = 1'b1; end
            4'd5: begin e_nif = d[15:0]; tif = 1'b1; end
            default: ;
        endcase
        check_all(req, trf, tif);
        @(negedge clk);
        check({req, " pulse end tune_rf"}, 32'(tune_rf), 32'd0);
        check({req, " pulse end tune_if"}, 32'(tune_if), 32'd0);
        repeat (3) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4: return "R7";
            4'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1
        check_all("R1", 1'b0, 1'b0);

        // R2 R11: bit order sweep over all addresses, writes while powered off
        for (int k = 0; k < 3; k++) begin
            for (int a = 0; a < 16; a++) begin
                logic [17:0] d;
                d = 18'((a * 7919 + k * 104729) ^ (k == 1 ? 32'h2AAAA : 32'h15555));
                write_word(4'(a), d, 0, tag_of(4'(a)));
            end
        end

        // R7 then R8: IF write keeps loop B selected
        write_word(4'd4, 18'h1F0F0, 0, "R7");
        write_word(4'd5, 18'h0BEEF, 0, "R8");
        write_word(4'd3, 18'h3C3C3, 0, "R6");

        // R4: every auxiliary select value, auto toggling (R11)
        for (int s = 0; s < 8; s++) begin
            write_word(4'd0, 18'((s << 12) | ((s & 1) << 3)), 0, "R4");
        end
        // R5 + R11: power bits with auto off, then auto on
        write_word(4'd0, 18'h0, 0, "R11");
        for (int p = 0; p < 4; p++) write_word(4'd2, 18'(p), 0, "R5");
        write_word(4'd0, 18'h00008, 0, "R11");

        // R3: leading don't-care bits of several lengths
        write_word(4'd5, 18'h01BEF, 9, "R3");
        write_word(4'd3, 18'h2468A, 1, "R3");
        write_word(4'd4, 18'h13579, 30, "R3");

        // R10: park a reserved word, then clock a valid word with enable high
        write_word(4'd7, 18'h3FFFF, 0, "R9");
        clock_word({18'h0AAAA, 4'd5});
        repeat (3) @(negedge clk);
        ser_en_n = 1'b0;
        repeat (4) @(negedge clk);
        ser_en_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R10", 1'b0, 1'b0);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule